// File: doc/BRIEF.md
# I2C Receive Byte Buffer with Transfer Counting

This block sits between the bit-level engine of an I2C peripheral and the host side. Each byte the engine assembles arrives with a one-cycle valid strobe and is stored in an eight-entry first-in first-out buffer. The host drains the buffer through a show-ahead read port. The block keeps an occupancy count and derives empty and full flags from it. It raises a level-type threshold request whenever the buffer holds at least a programmed number of bytes.

A byte counter tracks how many bytes of the current transfer have arrived. It emits a one-cycle done pulse when the programmed length is reached, and a programmed length of zero stands for 256 bytes. When the engine marks the first data bit of a new byte while both the buffer and the engine's shift register are full, a sticky overflow flag is set, and software clears it by writing one. A self-clearing flush bit empties the buffer. Deasserting the peripheral enable also empties it. A do-not-respond policy tells the slave logic whether an address match may be acknowledged.

Top module: `i2c_rx_buffer`

## Requirements
- R1: After reset, count is 0, empty is 1, full is 0, and ovf_flag, done_pulse and flush_bit are 0.
- R2: Accepted bytes leave in arrival order. rd_data shows the oldest stored byte while empty is 0. Count equals the number of stored bytes (0 to 8), empty is 1 exactly at count 0, and full is 1 exactly at count 8.
- R3: A byte strobed while full with no read in the same cycle is dropped and the contents are unchanged. A byte strobed while full together with a read is accepted.
- R4: thresh_irq is 1 while enable is 1 and count is greater than or equal to thresh. It drops in the same cycle the count goes below thresh.
- R5: A flush_wr pulse sets flush_bit on the next edge. On the following edge the buffer becomes empty and flush_bit returns to 0 by itself. Bytes and reads in that flush cycle have no effect.
- R6: While enable is 0, count is cleared to 0 at each edge, strobed bytes are neither stored nor counted, and thresh_irq is 0.
- R7: ovf_flag is set at the edge where first_bit, shreg_full and full are all 1 with enable 1. It stays set until an ovf_clr edge, and a set in the same cycle as a clear wins.
- R8: xfer_start zeroes the transfer byte counter. Each byte_vld with enable 1 counts, even when the byte is dropped. done_pulse is 1 for one cycle after the byte that makes the count equal rx_len, with rx_len 0 meaning 256. No further pulse occurs until the next xfer_start.
- R9: addr_ack_ok is 1 when dnr_en is 0. When dnr_en is 1, addr_ack_ok equals empty.
- R10: A read while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 clears the buffer |
| byte_vld | input | 1 | One-cycle strobe: a received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| first_bit | input | 1 | Marks the first data bit of a new byte |
| shreg_full | input | 1 | Engine shift register holds an undelivered byte |
| rd_en | input | 1 | Host read: pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| flush_wr | input | 1 | Software write of 1 to the flush bit |
| flush_bit | output | 1 | Flush bit readback, self-clearing |
| thresh | input | 4 | Threshold for the level request |
| rx_len | input | 8 | Bytes per transfer, 0 means 256 |
| xfer_start | input | 1 | Start of a new transfer, clears the byte counter |
| dnr_en | input | 1 | Do-not-respond policy enable |
| addr_ack_ok | output | 1 | Address match may be acknowledged |
| ovf_clr | input | 1 | Write-one-to-clear of the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| thresh_irq | output | 1 | Level request: count at or above thresh |
| done_pulse | output | 1 | One-cycle transfer-complete pulse |
| count | output | 4 | Occupancy count |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Buffer full |

## Verification
Stored contents, count, empty, full, ovf_flag and done_pulse change at the first clock edge after the stimulus that causes them. The exception is a flush: the buffer empties one edge later, after flush_bit has been set. thresh_irq and addr_ack_ok follow the count and the programmed inputs in the same cycle, with no added register. The bench drives each stimulus on the falling edge and advances a behavioural queue model by exactly one rising edge. It then compares every output on the next falling edge, so each result is checked in the cycle it becomes due.

// File: rtl/i2c_rxb_pkg.sv
package i2c_rxb_pkg;
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = cnt_bits(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic            pop,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [CNTW-1:0] count
);
  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] ONE  = CNTW'(1);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, wr_ptr_n;
  logic [AW-1:0]   rd_ptr, rd_ptr_n;
  logic [CNTW-1:0] count_n;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push) wr_ptr_n = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr_n = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count_n = count + ONE;
        2'b01:   count_n = count - ONE;
        default: count_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rxb_len_ctr.sv
module rxb_len_ctr #(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [LENW-1:0] len,
  output logic            done
);
  localparam int CW = LENW + 1;

  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] target;
  logic          reached, reached_n;
  logic          done_n;

  assign target = (len == '0) ? CW'(2 ** LENW) : {1'b0, len};

  always_comb begin
    cnt_n     = cnt;
    reached_n = reached;
    done_n    = 1'b0;
    if (start) begin
      cnt_n     = '0;
      reached_n = 1'b0;
    end else if (tick && !reached) begin
      cnt_n = cnt + 1'b1;
      if (cnt + 1'b1 == target) begin
        reached_n = 1'b1;
        done_n    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      reached <= 1'b0;
      done    <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      reached <= reached_n;
      done    <= done_n;
    end
  end
endmodule

// File: rtl/rxb_status.sv
module rxb_status
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THW   = 4,
  localparam int CNTW = cnt_bits(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [CNTW-1:0] count,
  input  logic [THW-1:0]  thresh,
  input  logic            flush_wr,
  output logic            flush_bit,
  input  logic            ovf_event,
  input  logic            ovf_clr,
  output logic            ovf_flag,
  input  logic            dnr_en,
  output logic            addr_ack_ok,
  output logic            thresh_irq
);
  localparam int CW = (THW > CNTW) ? THW : CNTW;

  logic          flush_n, ovf_n;
  logic [CW-1:0] cnt_x, th_x;

  assign cnt_x = CW'(count);
  assign th_x  = CW'(thresh);

  always_comb begin
    flush_n = flush_wr;
    ovf_n   = ovf_flag;
    if (ovf_event)    ovf_n = 1'b1;
    else if (ovf_clr) ovf_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_bit <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      flush_bit <= flush_n;
      ovf_flag  <= ovf_n;
    end
  end

  assign thresh_irq  = enable && (cnt_x >= th_x);
  assign addr_ack_ok = !dnr_en || (count == '0);
endmodule

// File: rtl/i2c_rx_buffer.sv
module i2c_rx_buffer
  import i2c_rxb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int THW   = 4,
  parameter int LENW  = 8,
  localparam int CNTW = cnt_bits(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            byte_vld,
  input  logic [DW-1:0]   byte_data,
  input  logic            first_bit,
  input  logic            shreg_full,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  input  logic            flush_wr,
  output logic            flush_bit,
  input  logic [THW-1:0]  thresh,
  input  logic [LENW-1:0] rx_len,
  input  logic            xfer_start,
  input  logic            dnr_en,
  output logic            addr_ack_ok,
  input  logic            ovf_clr,
  output logic            ovf_flag,
  output logic            thresh_irq,
  output logic            done_pulse,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            full
);
  logic live, clr, push_ok, pop_ok, ovf_event;

  assign live      = enable && !flush_bit;
  assign clr       = !live;
  assign empty     = (count == '0);
  assign full      = (count == CNTW'(DEPTH));
  assign pop_ok    = live && rd_en && !empty;
  assign push_ok   = live && byte_vld && (!full || pop_ok);
  assign ovf_event = enable && first_bit && shreg_full && full;

  rxb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .wdata (byte_data),
    .rdata (rd_data),
    .count (count)
  );

  rxb_len_ctr #(.LENW(LENW)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .start (xfer_start),
    .tick  (enable && byte_vld),
    .len   (rx_len),
    .done  (done_pulse)
  );

  rxb_status #(.DEPTH(DEPTH), .THW(THW)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .count       (count),
    .thresh      (thresh),
    .flush_wr    (flush_wr),
    .flush_bit   (flush_bit),
    .ovf_event   (ovf_event),
    .ovf_clr     (ovf_clr),
    .ovf_flag    (ovf_flag),
    .dnr_en      (dnr_en),
    .addr_ack_ok (addr_ack_ok),
    .thresh_irq  (thresh_irq)
  );
endmodule

// File: rtl/i2c_rx_buffer_chk.sv
module i2c_rx_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            byte_vld,
  input logic            first_bit,
  input logic            shreg_full,
  input logic            rd_en,
  input logic            flush_wr,
  input logic            flush_bit,
  input logic            ovf_clr,
  input logic            ovf_flag,
  input logic            done_pulse,
  input logic [CNTW-1:0] count,
  input logic            full
);
  // R2: occupancy never exceeds the depth
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  // R3: a byte strobed while full and not read leaves the buffer full
  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !flush_bit && full && !rd_en |=> full);

  // R5: flush empties the buffer and the bit clears itself
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_bit && !flush_wr |=> (count == '0) && !flush_bit);

  // R6: disabled means empty on the next edge
  p_disable_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);

  // R7: overflow condition sets the flag
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable && first_bit && shreg_full && full |=> ovf_flag);

  // R7: the flag is sticky without a clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  // R8: done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
endmodule

bind i2c_rx_buffer i2c_rx_buffer_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .byte_vld   (byte_vld),
  .first_bit  (first_bit),
  .shreg_full (shreg_full),
  .rd_en      (rd_en),
  .flush_wr   (flush_wr),
  .flush_bit  (flush_bit),
  .ovf_clr    (ovf_clr),
  .ovf_flag   (ovf_flag),
  .done_pulse (done_pulse),
  .count      (count),
  .full       (full)
);

// File: tb/i2c_rx_buffer_tb_top.sv
module i2c_rx_buffer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, byte_vld = 1'b0, first_bit = 1'b0, shreg_full = 1'b0;
  logic rd_en = 1'b0, flush_wr = 1'b0, xfer_start = 1'b0, dnr_en = 1'b0, ovf_clr = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [3:0] thresh = 4'd0;
  logic [7:0] rx_len = 8'd0;
  logic [7:0] rd_data;
  logic flush_bit, addr_ack_ok, ovf_flag, thresh_irq, done_pulse, empty, full;
  logic [3:0] count;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned q[$];
  bit m_flush = 0, m_ovf = 0, m_done = 0, m_reached = 0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  i2c_rx_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .byte_vld(byte_vld),
    .byte_data(byte_data), .first_bit(first_bit), .shreg_full(shreg_full),
    .rd_en(rd_en), .rd_data(rd_data), .flush_wr(flush_wr), .flush_bit(flush_bit),
    .thresh(thresh), .rx_len(rx_len), .xfer_start(xfer_start), .dnr_en(dnr_en),
    .addr_ack_ok(addr_ack_ok), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .thresh_irq(thresh_irq), .done_pulse(done_pulse), .count(count),
    .empty(empty), .full(full));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = q.size();
    chk("R2", "count", int'(count), n);
    chk("R2", "empty", int'(empty), (n == 0) ? 1 : 0);
    chk("R2", "full", int'(full), (n == 8) ? 1 : 0);
    if (n > 0) chk("R2", "rd_data", int'(rd_data), int'(q[0]));
    chk("R4", "thresh_irq", int'(thresh_irq), (enable && n >= int'(thresh)) ? 1 : 0);
    chk("R5", "flush_bit", int'(flush_bit), int'(m_flush));
    chk("R7", "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("R8", "done_pulse", int'(done_pulse), int'(m_done));
    chk("R9", "addr_ack_ok", int'(addr_ack_ok), (!dnr_en || n == 0) ? 1 : 0);
  endtask

  // advance model by one rising edge using the inputs now applied
  task automatic step();
    int n = q.size();
    bit live = enable && !m_flush;
    bit pop = live && rd_en && n > 0;
    bit push = live && byte_vld && (n < 8 || pop);
    bit ovf_set = enable && first_bit && shreg_full && n == 8;
    int target = (rx_len == 0) ? 256 : int'(rx_len);
    bit nflush = flush_wr;
    m_done = 0;
    if (xfer_start) begin
      m_cnt = 0; m_reached = 0;
    end else if (enable && byte_vld && !m_reached) begin
      m_cnt++;
      if (m_cnt == target) begin m_done = 1; m_reached = 1; end
    end
    if (ovf_set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    if (!live) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push) q.push_back(byte_data);
    end
    m_flush = nflush;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_in();
    byte_vld = 0; rd_en = 0; flush_wr = 0; xfer_start = 0; ovf_clr = 0; first_bit = 0;
  endtask

  task automatic put(input byte unsigned d, input bit rd);
    idle_in(); byte_vld = 1; byte_data = d; rd_en = rd; step();
  endtask

  task automatic get();
    idle_in(); rd_en = 1; step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "count", int'(count), 0);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "ovf_flag", int'(ovf_flag), 0);
    chk("R1", "done_pulse", int'(done_pulse), 0);
    chk("R1", "flush_bit", int'(flush_bit), 0);
    rst_n = 1;
    @(negedge clk);
    enable = 1; thresh = 4'd3; rx_len = 8'd40;
    idle_in(); xfer_start = 1; step();
    // R2: order and count
    put(8'hA1, 0); put(8'hB2, 0); put(8'hC3, 0);
    get(); get();
    // R10: read while empty
    get(); get();
    // R3: fill, drop when full, push+pop when full
    for (int i = 0; i < 9; i++) put(byte'(8'h10 + i), 0);
    put(8'hEE, 0);
    put(8'h77, 1);
    // R9: do-not-respond while not empty
    dnr_en = 1; idle_in(); step();
    // R7: overflow requires both full
    idle_in(); first_bit = 1; shreg_full = 0; step();
    idle_in(); first_bit = 1; shreg_full = 1; step();
    idle_in(); step();
    idle_in(); ovf_clr = 1; first_bit = 1; shreg_full = 1; step();
    idle_in(); ovf_clr = 1; shreg_full = 0; step();
    // R4: drain across several thresholds
    thresh = 4'd8; idle_in(); step();
    thresh = 4'd5;
    for (int i = 0; i < 5; i++) get();
    thresh = 4'd0; idle_in(); step();
    // R5: flush with activity in the flush cycle
    put(8'h55, 0); put(8'h66, 0);
    idle_in(); flush_wr = 1; step();
    idle_in(); byte_vld = 1; byte_data = 8'h99; rd_en = 1; step();
    idle_in(); step();
    // R6: disable clears and ignores
    put(8'h31, 0); put(8'h32, 0);
    enable = 0; put(8'h33, 0); put(8'h34, 0);
    enable = 1; idle_in(); step();
    dnr_en = 0;
    // R8: short transfer length
    rx_len = 8'd5; idle_in(); xfer_start = 1; step();
    for (int i = 0; i < 7; i++) put(byte'(i), 1);
    // R8: length 0 means 256
    rx_len = 8'd0; idle_in(); xfer_start = 1; step();
    for (int i = 0; i < 258; i++) put(byte'(i), 1);
    idle_in(); step();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule